// File: doc/BRIEF.md
# GPIO Interrupt Detect and Status Unit

This unit holds the per-pin interrupt logic of a 95-pin general purpose I/O controller. Every pin delivers an input level that has already been synchronized to the clock, together with two configuration bits that a neighbouring block keeps: a trigger-kind bit (0 for edge, 1 for level) and a polarity-invert bit. From these the unit detects one of four conditions on each pin: rising edge, falling edge, level low or level high.

A detected condition sets that pin's bit in a status bitmap. Software clears a status bit by writing 1 to it. A separate enable bitmap chooses which pins can interrupt. One interrupt output, shared by all pins, is raised while any pin has both its status bit and its enable bit set. Software reads and writes the two bitmaps through a simple word-wide register port. Each bitmap takes three 32-bit words, and bit `i` of word `w` belongs to pin `32*w + i`.

Top module: `gpi_irq_unit`

## Requirements
- R1: With trigger code {kind, invert} = 2'b00, a pin whose sampled level goes from 0 to 1 sets its status bit at the clock edge where the new level is first sampled. A 1-to-0 change, or a level that does not change, sets nothing.
- R2: With code 2'b01, a pin going from 1 to 0 sets its status bit at the clock edge where the new level is first sampled. A 0-to-1 change sets nothing.
- R3: With code 2'b10 (level low) or 2'b11 (level high), the status bit is set again at every edge while the level matches the selected polarity. A write-1 clear therefore takes effect only after the level has stopped matching.
- R4: Status words are at byte addresses 0x80, 0x84 and 0x88. Writing 1 to a status bit clears it at the write edge. Writing 0 leaves that bit unchanged.
- R5: Enable words are at 0x90, 0x94 and 0x98. A write replaces the word, and a read returns the stored value. Status bits are set whatever the enable bits hold.
- R6: `irq_out` is a register of the OR over all pins of (status AND enable). It rises one edge after a pending bit appears and falls one edge after the last pending bit goes away.
- R7: When a detected condition and a write-1 clear reach the same status bit at the same edge, the bit ends up set.
- R8: Reset clears status, enable and `irq_out`. The unit keeps tracking pin levels during reset, so a pin that is held high across the release of reset in rising-edge mode produces no event.
- R9: Word 2, bit 31 (there is no pin 95) always reads 0 in both bitmaps. Addresses other than the six word addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_level | input | 95 | Synchronized input level of each pin |
| trig_kind | input | 95 | Per-pin trigger kind: 0 edge, 1 level |
| trig_inv | input | 95 | Per-pin polarity invert |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Byte address of the word to read or write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Shared interrupt request |

## Verification
Under level triggering the bench clears a status bit while the level still matches and checks that the bit stays set. A design that treated levels as one-shot events would lose the bit. The bench also lands a write-1 clear in the same cycle as a new edge on that pin. If the clear won, the edge would be dropped silently. It pins down the single cycle of delay on `irq_out` in both directions, and checks that a pin held high while reset is released does not report a phantom rising edge. It also checks the bit past the last pin and writes to unmapped addresses, which catches a decoder that aliases addresses or stores bits that have no pin behind them.

// File: rtl/gpi_irq_pkg.sv
package gpi_irq_pkg;

    // Trigger code as {kind, invert}.
    typedef enum logic [1:0] {
        TRIG_RISE = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_LOW  = 2'b10,
        TRIG_HIGH = 2'b11
    } trig_mode_e;

    // Which bitmap a register address selects.
    typedef struct packed {
        logic stat;
        logic en;
    } word_hit_t;

    function automatic logic trig_hit(trig_mode_e mode, logic cur, logic prev);
        logic r;
        case (mode)
            TRIG_RISE: r = cur & ~prev;
            TRIG_FALL: r = ~cur & prev;
            TRIG_LOW:  r = ~cur;
            default:   r = cur;
        endcase
        return r;
    endfunction

    function automatic int unsigned word_addr(int unsigned base, int unsigned idx,
                                              int unsigned bytes_per_word);
        return base + idx * bytes_per_word;
    endfunction

endpackage

// File: rtl/gpi_edge_detect.sv
module gpi_edge_detect
    import gpi_irq_pkg::*;
#(
    parameter int NUM_PINS = 95
) (
    input  logic                clk,
    input  logic [NUM_PINS-1:0] pin_level,
    input  logic [NUM_PINS-1:0] trig_kind,
    input  logic [NUM_PINS-1:0] trig_inv,
    output logic [NUM_PINS-1:0] hit
);

    // Level history is tracked in and out of reset so that leaving
    // reset never produces a spurious edge.
    logic [NUM_PINS-1:0] prev_q;

    always_ff @(posedge clk) begin
        prev_q <= pin_level;
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        trig_mode_e mode;
        assign mode   = trig_mode_e'({trig_kind[p], trig_inv[p]});
        assign hit[p] = trig_hit(mode, pin_level[p], prev_q[p]);
    end

endmodule

// File: rtl/gpi_status_bank.sv
module gpi_status_bank
    import gpi_irq_pkg::*;
#(
    parameter int NUM_PINS  = 95,
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int STAT_BASE = 'h80,
    parameter int EN_BASE   = 'h90
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] hit,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    output logic [NUM_PINS-1:0] status,
    output logic [NUM_PINS-1:0] enable
);

    localparam int NUM_WORDS      = (NUM_PINS + WORD_W - 1) / WORD_W;
    localparam int PAD_W          = NUM_WORDS * WORD_W;
    localparam int BYTES_PER_WORD = WORD_W / 8;

    word_hit_t [NUM_WORDS-1:0] sel;
    logic [NUM_PINS-1:0]       clr;
    logic [NUM_PINS-1:0]       stat_q;
    logic [NUM_PINS-1:0]       en_q;
    logic [PAD_W-1:0]          stat_pad;
    logic [PAD_W-1:0]          en_pad;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        assign sel[w].stat = (reg_addr == ADDR_W'(word_addr(STAT_BASE, w, BYTES_PER_WORD)));
        assign sel[w].en   = (reg_addr == ADDR_W'(word_addr(EN_BASE, w, BYTES_PER_WORD)));
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_bit
        localparam int W = p / WORD_W;
        localparam int B = p % WORD_W;

        assign clr[p] = reg_wr & sel[W].stat & reg_wdata[B];

        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[p] <= 1'b0;
            end else if (reg_wr && sel[W].en) begin
                en_q[p] <= reg_wdata[B];
            end
        end
    end

    // A new event outranks a clear landing at the same edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr) | hit;
        end
    end

    assign stat_pad = PAD_W'(stat_q);
    assign en_pad   = PAD_W'(en_q);

    always_comb begin
        reg_rdata = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (sel[w].stat) reg_rdata = stat_pad[w*WORD_W +: WORD_W];
            if (sel[w].en)   reg_rdata = en_pad[w*WORD_W +: WORD_W];
        end
    end

    assign status = stat_q;
    assign enable = en_q;

endmodule

// File: rtl/gpi_irq_summary.sv
module gpi_irq_summary #(
    parameter int NUM_PINS = 95
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] status,
    input  logic [NUM_PINS-1:0] enable,
    output logic                irq_out
);

    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(status & enable);
        end
    end

    assign irq_out = irq_q;

endmodule

// File: rtl/gpi_irq_unit.sv
module gpi_irq_unit #(
    parameter int NUM_PINS  = 95,
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int STAT_BASE = 'h80,
    parameter int EN_BASE   = 'h90
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_level,
    input  logic [NUM_PINS-1:0] trig_kind,
    input  logic [NUM_PINS-1:0] trig_inv,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    output logic                irq_out
);

    logic [NUM_PINS-1:0] hit;
    logic [NUM_PINS-1:0] status;
    logic [NUM_PINS-1:0] enable;

    gpi_edge_detect #(
        .NUM_PINS (NUM_PINS)
    ) u_detect (
        .clk       (clk),
        .pin_level (pin_level),
        .trig_kind (trig_kind),
        .trig_inv  (trig_inv),
        .hit       (hit)
    );

    gpi_status_bank #(
        .NUM_PINS  (NUM_PINS),
        .WORD_W    (WORD_W),
        .ADDR_W    (ADDR_W),
        .STAT_BASE (STAT_BASE),
        .EN_BASE   (EN_BASE)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .hit       (hit),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .status    (status),
        .enable    (enable)
    );

    gpi_irq_summary #(
        .NUM_PINS (NUM_PINS)
    ) u_summary (
        .clk     (clk),
        .rst     (rst),
        .status  (status),
        .enable  (enable),
        .irq_out (irq_out)
    );

endmodule

// File: rtl/gpi_irq_unit_chk.sv
module gpi_irq_unit_chk #(
    parameter int NUM_PINS = 95
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_PINS-1:0] hit,
    input logic [NUM_PINS-1:0] status,
    input logic [NUM_PINS-1:0] enable,
    input logic                reg_wr,
    input logic                irq_out
);

    // R1 R2 R3 R7: every detected condition leaves its status bit set
    event_sets_status_chk: assert property (@(posedge clk) disable iff (rst)
        (|hit) |=> ((status & $past(hit)) == $past(hit)));

    // R4: status bits only fall on a register write
    drop_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_wr |=> (($past(status) & ~status) == '0));

    // R5: a newly set status bit always traces back to a detected condition
    set_needs_event_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((status & ~$past(status) & ~$past(hit)) == '0));

    // R6
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (|(status & enable)) |=> irq_out);

    // R6
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(|(status & enable)) |=> !irq_out);

    // R8
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (status == '0 && enable == '0 && !irq_out));

endmodule

bind gpi_irq_unit gpi_irq_unit_chk #(
    .NUM_PINS (NUM_PINS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .hit     (hit),
    .status  (status),
    .enable  (enable),
    .reg_wr  (reg_wr),
    .irq_out (irq_out)
);

// File: tb/tb_gpi_irq_unit.sv
`timescale 1ns/1ps
module tb_gpi_irq_unit;

    localparam int NP = 95;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pin_level = '0;
    logic [NP-1:0] trig_kind = '0;
    logic [NP-1:0] trig_inv  = '0;
    logic          reg_wr    = 1'b0;
    logic [7:0]    reg_addr  = 8'h00;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    gpi_irq_unit dut (
        .clk       (clk),
        .rst       (rst),
        .pin_level (pin_level),
        .trig_kind (trig_kind),
        .trig_inv  (trig_inv),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    typedef struct packed {
        logic [7:0] pin;
        logic       kind;
        logic       inv;
        logic       lv0;
        logic       lv1;
        logic       exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'd0,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R1 rise seen
        '{8'd31, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R1 fall ignored
        '{8'd32, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},  // R2 fall seen
        '{8'd63, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},  // R2 rise ignored
        '{8'd64, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},  // R3 level low
        '{8'd94, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},  // R3 level low, stays high
        '{8'd94, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // R3 level high
        '{8'd40, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // R3 level high, stays low
        '{8'd5,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1},  // R3 held level survives clear
        '{8'd70, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},  // R1 steady high
        '{8'd33, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},  // R3 held low survives clear
        '{8'd90, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}   // R2 steady low
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic clear_all();
        wr(8'h80, 32'hFFFF_FFFF);
        wr(8'h84, 32'hFFFF_FFFF);
        wr(8'h88, 32'hFFFF_FFFF);
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] e;

        // R8: pin 10 high through reset in rising-edge mode
        pin_level[10] = 1'b1;
        tick(4);
        rst = 1'b0;
        tick(3);
        rd(8'h80, d); chk("R8 no edge at reset release", d, 32'h0);
        rd(8'h84, d); chk("R8 status word1", d, 32'h0);
        rd(8'h98, d); chk("R8 enable word2", d, 32'h0);
        chk("R8 irq low", {31'b0, irq_out}, 32'h0);

        // R5 enable read/write, R9 padding and unmapped addresses
        wr(8'h90, 32'hA5A5_A5A5);
        rd(8'h90, d); chk("R5 enable readback", d, 32'hA5A5_A5A5);
        wr(8'h98, 32'hFFFF_FFFF);
        rd(8'h98, d); chk("R9 no pin 95 in enable", d, 32'h7FFF_FFFF);
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h92, 32'hFFFF_FFFF);
        rd(8'h40, d); chk("R9 unmapped reads zero", d, 32'h0);
        rd(8'h94, d); chk("R9 unmapped write ignored", d, 32'h0);
        wr(8'h90, 32'h0);
        wr(8'h98, 32'h0);

        // Vector table walk: R1 R2 R3
        for (int k = 0; k < NV; k++) begin
            pin_level = '0; trig_kind = '0; trig_inv = '0;
            trig_kind[VECS[k].pin] = VECS[k].kind;
            trig_inv[VECS[k].pin]  = VECS[k].inv;
            pin_level[VECS[k].pin] = VECS[k].lv0;
            tick(3);
            clear_all();
            pin_level[VECS[k].pin] = VECS[k].lv1;
            tick(2);
            rd(8'h80 + 8'(4 * (VECS[k].pin / 32)), d);
            e = VECS[k].exp ? (32'h1 << (VECS[k].pin % 32)) : 32'h0;
            chk($sformatf("R1/R2/R3 vector %0d pin %0d", k, VECS[k].pin), d, e);
        end

        pin_level = '0; trig_kind = '0; trig_inv = '0;
        tick(2);
        clear_all();
        rd(8'h88, d); chk("R4 clear all", d, 32'h0);

        // R6 irq timing
        wr(8'h90, 32'h0000_0008);
        pin_level[3] = 1'b1;
        tick(1);
        rd(8'h80, d); chk("R6 status set", d, 32'h8);
        chk("R6 irq not yet", {31'b0, irq_out}, 32'h0);
        tick(1);
        chk("R6 irq one edge later", {31'b0, irq_out}, 32'h1);
        wr(8'h80, 32'h8);
        chk("R6 irq held at clear edge", {31'b0, irq_out}, 32'h1);
        tick(1);
        chk("R6 irq falls", {31'b0, irq_out}, 32'h0);

        // R5: status set while disabled, no irq
        pin_level[7] = 1'b1;
        tick(2);
        rd(8'h80, d); chk("R5 disabled pin still latches", d, 32'h80);
        chk("R5 disabled pin no irq", {31'b0, irq_out}, 32'h0);
        wr(8'h80, 32'h0);
        rd(8'h80, d); chk("R4 write zero keeps bit", d, 32'h80);
        wr(8'h80, 32'h80);
        rd(8'h80, d); chk("R4 write one clears", d, 32'h0);

        // R7: edge and clear at the same edge
        pin_level[20] = 1'b1;
        wr(8'h80, 32'h0010_0000);
        rd(8'h80, d); chk("R7 set wins over clear", d, 32'h0010_0000);
        wr(8'h80, 32'h0010_0000);
        rd(8'h80, d); chk("R7 later clear works", d, 32'h0);

        // R3: level-high clear only after the level goes away
        trig_kind[50] = 1'b1; trig_inv[50] = 1'b1; pin_level[50] = 1'b1;
        tick(2);
        wr(8'h84, 32'h0004_0000);
        rd(8'h84, d); chk("R3 clear while level holds", d, 32'h0004_0000);
        pin_level[50] = 1'b0;
        tick(1);
        wr(8'h84, 32'h0004_0000);
        rd(8'h84, d); chk("R3 clear after level drops", d, 32'h0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule